// File: doc/BRIEF.md
# Look-ahead Synchronous FIFO

This block is a single-clock FIFO whose read side shows the oldest stored word on its data output before any read is requested. A read strobe takes the word currently shown, and the next word replaces it on the bus. The consumer treats `valid` as "a word is here" and `rdEn` as "I took it". This makes the block a drop-in elastic buffer in front of logic that cannot wait an extra cycle after asking for data.

Inside, an ordinary ring memory with a registered read port holds most of the words. A two-entry prefetch stage of output registers sits after the memory and refills whenever it has room, which lets reads run back to back at one word per clock. The output registers also hold data, so the block stores `DEPTH + 2` words. Because a word must pass through the registered memory read and then into the prefetch stage, a word written into an empty FIFO is not shown until two edges after its write. For the same reason, `empty` follows the prefetch stage and not the memory.

The write side reports each accepted write, and each write that was refused because the FIFO was full. The read side reports each read attempted while nothing was shown.

Top module: `lookahead_fifo`

## Requirements
- R1: While `valid` is high and `rdEn` is low, `rdData` keeps showing the oldest unread word unchanged. A clock edge with `rdEn` and `valid` both high consumes that word, and words leave in exactly the order they were accepted.
- R2: A word accepted at a clock edge while nothing older is unread becomes visible after the second following edge: `valid` rises and `empty` falls two cycles after the write.
- R3: `empty` is always the inverse of `valid`. After the edge that consumes the last visible word with no other word ready, `empty` is high in the next cycle.
- R4: The FIFO holds up to `DEPTH + 2` words. `full` is high exactly when that many words are held.
- R5: A write strobe while `full` is high is ignored, so the stored contents and their order are unchanged. In the following cycle `wrAck` is low and `overflow` is high for one cycle.
- R6: A read strobe while `valid` is low consumes nothing. In the following cycle `underflow` is high for one cycle.
- R7: `wrAck` is high for exactly the one cycle after each edge at which a write was accepted.
- R8: `almostEmpty` is high when at most one word is held. `almostFull` is high when the held count is at least `DEPTH + 1`, that is, when at most one more write fits.
- R9: When reads are issued every cycle and enough words were written earlier, `valid` stays high on every cycle, so one word per clock is delivered.
- R10: A read and a write at the same edge while exactly one word is held lose no word and duplicate none. The new word appears two edges after its write.
- R11: During reset, `valid`, `full`, `almostFull`, `wrAck`, `overflow` and `underflow` are low, and `empty` and `almostEmpty` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrData | input | WIDTH | Word to write |
| full | output | 1 | No room for another word |
| almostFull | output | 1 | At most one more word fits |
| wrAck | output | 1 | Previous edge accepted a write |
| overflow | output | 1 | Previous edge refused a write because the FIFO was full |
| rdEn | input | 1 | Read strobe; consumes the shown word |
| rdData | output | WIDTH | Oldest unread word, shown ahead of the read |
| valid | output | 1 | `rdData` holds a word |
| empty | output | 1 | No word shown |
| almostEmpty | output | 1 | At most one word held |
| underflow | output | 1 | Previous edge saw a read with no word shown |

## Verification
The bench runs several input patterns.

- **Isolated write into an empty FIFO.** This tells the two-cycle presentation latency apart from a one- or three-cycle path.
- **Burst of writes past capacity, then reads past empty.** This separates the true capacity of `DEPTH + 2` from the memory depth alone, and shows that refused writes leave no trace.
- **Read and write together with a single word held.** This catches lost or doubled words in the prefetch hand-over.
- **Continuous streaming with a read every cycle.** This exposes any refill bubble.
- **Long random mix with biased write and read rates.** This compares every flag and the shown word against a behavioural queue on every cycle.

// File: rtl/lookahead_fifo_pkg.sv
package lookahead_fifo_pkg;

  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic memWr;     // store wrData at wrAddr
    logic memRd;     // capture memory word at rdAddr into read register
    logic pop;       // head slot consumed, shift slot 1 down
    logic land;      // read register holds a word to place in a slot
    logic landSlot;  // slot index that receives the landing word
  } fifoStrobe_t;

endpackage

// File: rtl/lookahead_fifo_dp.sv
module lookahead_fifo_dp
  import lookahead_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       stb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  headData
);

  localparam int NSLOT = 2;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdReg;
  logic [WIDTH-1:0] slot [NSLOT];

  // Registered-read ring storage; a read and write to one address return the old word
  always_ff @(posedge clk) begin
    if (stb.memWr) mem[wrAddr] <= wrData;
    if (stb.memRd) rdReg <= mem[rdAddr];
  end

  // Prefetch slots: slot 0 drives the output bus
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [WIDTH-1:0] shiftIn;
    if (i == NSLOT - 1) begin : g_last
      assign shiftIn = slot[i];
    end else begin : g_mid
      assign shiftIn = slot[i+1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slot[i] <= '0;
      end else begin
        if (stb.pop) slot[i] <= shiftIn;
        if (stb.land && (int'(stb.landSlot) == i)) slot[i] <= rdReg;
      end
    end
  end

  assign headData = slot[0];

  // R1: a landing word never targets the upper slot during a shift
  land_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.land && stb.pop |-> !stb.landSlot);

endmodule

// File: rtl/lookahead_fifo_ctrl.sv
module lookahead_fifo_ctrl
  import lookahead_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW  = $clog2(DEPTH),
  localparam int CAP = DEPTH + 2,
  localparam int CW  = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  output fifoStrobe_t   stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          full,
  output logic          almostFull,
  output logic          wrAck,
  output logic          overflow,
  output logic          valid,
  output logic          empty,
  output logic          almostEmpty,
  output logic          underflow
);

  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   memCount;
  logic          inflight;
  logic [1:0]    slotCnt;
  logic [CW-1:0] fill;

  logic          wrOk, popOk, memRdOk;
  logic [2:0]    pending;

  assign wrOk    = wrEn && (fill != CW'(CAP));
  assign popOk   = rdEn && (slotCnt != 2'd0);
  assign pending = {1'b0, slotCnt} + {2'b0, inflight} - {2'b0, popOk};
  assign memRdOk = (memCount != '0) && (pending < 3'd2);

  always_comb begin
    stb.memWr    = wrOk;
    stb.memRd    = memRdOk;
    stb.pop      = popOk;
    stb.land     = inflight;
    stb.landSlot = (slotCnt - {1'b0, popOk}) != 2'd0;
  end

  assign wrAddr = wrPtr;
  assign rdAddr = rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      memCount  <= '0;
      inflight  <= 1'b0;
      slotCnt   <= 2'd0;
      fill      <= '0;
      wrAck     <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (wrOk)    wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (memRdOk) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      memCount  <= memCount + (AW+1)'(wrOk) - (AW+1)'(memRdOk);
      inflight  <= memRdOk;
      slotCnt   <= slotCnt - {1'b0, popOk} + {1'b0, inflight};
      fill      <= fill + CW'(wrOk) - CW'(popOk);
      wrAck     <= wrOk;
      overflow  <= wrEn && !wrOk;
      underflow <= rdEn && (slotCnt == 2'd0);
    end
  end

  assign full        = (fill == CW'(CAP));
  assign almostFull  = (fill >= CW'(CAP - 1));
  assign almostEmpty = (fill <= CW'(1));
  assign valid       = (slotCnt != 2'd0);
  assign empty       = !valid;

  // R5
  ovf_after_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    full && wrEn |=> overflow && !wrAck);

  // R6
  udf_chk: assert property (@(posedge clk) disable iff (!rstN)
    !valid && rdEn |=> underflow);

  // R3
  empty_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(empty) |-> $past(rdEn));

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    full && !rdEn |=> full);

  // R7
  ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !full |=> wrAck);

  // R4
  count_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(fill) == int'(memCount) + int'(inflight) + int'(slotCnt));

endmodule

// File: rtl/lookahead_fifo.sv
module lookahead_fifo
  import lookahead_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             full,
  output logic             almostFull,
  output logic             wrAck,
  output logic             overflow,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             valid,
  output logic             empty,
  output logic             almostEmpty,
  output logic             underflow
);

  fifoStrobe_t   stb;
  logic [AW-1:0] wrAddr, rdAddr;

  lookahead_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .stb        (stb),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .full       (full),
    .almostFull (almostFull),
    .wrAck      (wrAck),
    .overflow   (overflow),
    .valid      (valid),
    .empty      (empty),
    .almostEmpty(almostEmpty),
    .underflow  (underflow)
  );

  lookahead_fifo_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .wrData  (wrData),
    .headData(rdData)
  );

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid && !rdEn |=> valid && $stable(rdData));

endmodule

// File: tb/tb_lookahead_fifo.sv
module tb_lookahead_fifo;

  localparam int WIDTH = 8;
  localparam int DEPTH = 8;
  localparam int CAP   = DEPTH + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic full, almostFull, wrAck, overflow;
  logic [WIDTH-1:0] rdData;
  logic valid, empty, almostEmpty, underflow;

  always #10 clk = ~clk;

  lookahead_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .full(full), .almostFull(almostFull),
    .wrAck(wrAck), .overflow(overflow),
    .rdEn(rdEn), .rdData(rdData), .valid(valid), .empty(empty),
    .almostEmpty(almostEmpty), .underflow(underflow)
  );

  typedef struct { logic [WIDTH-1:0] d; int e; } entry_t;
  entry_t q[$];
  int  edgeNum = 0;
  int  total = 0, bad = 0;
  bit  done = 1'b0;
  bit  expAck = 0, expOvf = 0, expUdf = 0;
  string phase = "idle";

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] cycle %0d: actual=%0d expected=%0d", tag, phase, edgeNum, act, exp);
    end
  endtask

  function automatic bit modelValid();
    return (q.size() > 0) && (q[0].e <= edgeNum - 2);
  endfunction

  task automatic compareAll();
    bit v;
    v = modelValid();
    chk("R2 valid", int'(valid), int'(v));
    chk("R3 empty", int'(empty), int'(!v));
    if (v) chk("R1 head data", int'(rdData), int'(q[0].d));
    chk("R4 full", int'(full), int'(q.size() == CAP));
    chk("R8 almostFull", int'(almostFull), int'(q.size() >= CAP - 1));
    chk("R8 almostEmpty", int'(almostEmpty), int'(q.size() <= 1));
    chk("R7 wrAck", int'(wrAck), int'(expAck));
    chk("R5 overflow", int'(overflow), int'(expOvf));
    chk("R6 underflow", int'(underflow), int'(expUdf));
  endtask

  // one cycle: check the state after the last edge, then drive the next edge
  task automatic tick(input bit w, input bit r);
    bit v;
    bit acc;
    entry_t ne;
    @(negedge clk);
    edgeNum++;
    compareAll();
    wrEn   = w;
    rdEn   = r;
    wrData = WIDTH'($urandom);
    v   = modelValid();
    acc = w && (q.size() < CAP);
    if (r && v) void'(q.pop_front());
    if (acc) begin
      ne.d = wrData;
      ne.e = edgeNum + 1;
      q.push_back(ne);
    end
    expAck = acc;
    expOvf = w && !acc;
    expUdf = r && !v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    phase = "R11 reset";
    chk("R11 valid", int'(valid), 0);
    chk("R11 empty", int'(empty), 1);
    chk("R11 full", int'(full), 0);
    chk("R11 almostFull", int'(almostFull), 0);
    chk("R11 almostEmpty", int'(almostEmpty), 1);
    chk("R11 wrAck", int'(wrAck), 0);
    chk("R11 overflow", int'(overflow), 0);
    chk("R11 underflow", int'(underflow), 0);
    rstN = 1'b1;

    // R2 single write latency
    phase = "R2 single write";
    tick(0, 0);
    tick(1, 0);
    repeat (4) tick(0, 0);
    tick(0, 1);
    tick(0, 0);

    // R4/R5 fill past capacity, then R6/R3 drain past empty
    phase = "R4 R5 overfill";
    repeat (CAP + 3) tick(1, 0);
    repeat (3) tick(0, 0);
    phase = "R6 R3 overdrain";
    repeat (CAP + 3) tick(0, 1);
    tick(0, 0);

    // R10 overlap with one word held
    phase = "R10 overlap";
    tick(1, 0);
    repeat (3) tick(0, 0);
    tick(1, 1);
    repeat (3) tick(0, 0);
    tick(0, 1);
    tick(0, 0);

    // R9 streaming: prefill, then read and write every cycle
    phase = "R9 stream";
    repeat (4) tick(1, 0);
    repeat (3) tick(0, 0);
    for (int i = 0; i < 40; i++) begin
      tick(1, 1);
      chk("R9 no bubble", int'(valid), 1);
    end
    repeat (CAP + 2) tick(0, 1);

    // Random mixes with different write and read rates
    for (int p = 0; p < 3; p++) begin
      int wp = (p == 0) ? 70 : (p == 1) ? 30 : 50;
      int rp = (p == 0) ? 30 : (p == 1) ? 70 : 50;
      phase = $sformatf("R1 random mix %0d", p);
      for (int i = 0; i < 1500; i++)
        tick(($urandom % 100) < wp, ($urandom % 100) < rp);
    end
    tick(0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule